// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block sits beside the CPU of a small microcontroller and decides which clocks run. When the CPU issues a sleep request, the block reads a three-bit mode code and enters one of four low-power states: idle, power-save, power-down or standby. In each state it drives enable lines for the CPU clock, the main oscillator, the low-frequency asynchronous oscillator, the timer clock, the display-controller clock and one clock per general peripheral. It then watches the wake sources that are allowed in that state, and returns to the running state when one of them fires.

Power-save keeps the timer and display controller alive if they are enabled. The two oscillators run only when one of those modules actually draws from them. Standby keeps the main oscillator warm and holds the CPU off for a fixed restart count after the wake event. A power-reduction mask, written by software, can stop individual peripheral clocks while the CPU runs or idles. Clearing a mask bit gives the peripheral its clock back, and the peripheral resumes from its frozen state.

Top module: `slp_clk_ctrl`

## Requirements
- R1: After reset the controller is running: `cpu_run`, `main_osc_en` and `async_osc_en` are 1, the power-reduction mask is zero, and every `periph_clk_en` bit is 1.
- R2: While running, a rising edge of `sleep_req` is decoded from `sleep_mode`. The codes are: 000 idle, 010 power-down, 011 power-save, 110 standby when `xtal_opt` is 1 and power-down when `xtal_opt` is 0. Any other code is ignored. A request that is held high, or that arrives while asleep, is ignored. An accepted request drops `cpu_run` at the next cycle.
- R3: In idle only the CPU clock stops. Both oscillators stay on, and the peripheral clocks follow the mask. Any qualified wake source returns the controller to running in the next cycle: `ext_wake`, `disp_irq`, or a qualified timer event.
- R4: In power-down every clock enable is 0. Only `ext_wake` wakes the controller, which is running in the next cycle. Timer and display events have no effect.
- R5: In power-save, `tmr_clk_en` equals `tmr_en` and `disp_clk_en` equals `disp_en`. The CPU and peripheral clocks are off.
- R6: In power-save, `main_osc_en` is 1 only if an enabled timer or display controller selects the synchronous source (select bit 0). `async_osc_en` is 1 only if an enabled one selects the asynchronous source (select bit 1).
- R7: In power-save, a timer overflow or compare event wakes the controller only when its own interrupt enable and `gie` are both 1. `disp_irq` and `ext_wake` also wake it.
- R8: In standby, `main_osc_en` is 1 and all other enables are 0. Only `ext_wake` ends standby.
- R9: `cpu_run` rises exactly RESTART_CYC (default 6) clock edges after the edge that samples the standby wake event. During that count the main oscillator stays on, and further wake events do not restart the count.
- R10: A write of `prr_wdata` with `prr_we` takes effect after one edge. While running or idle, bit i set forces `periph_clk_en[i]` to 0, and bit i clear gives it 1.
- R11: In power-save, power-down, standby and the standby restart count, all `periph_clk_en` bits are 0 whatever the mask holds. The mask is kept, and it applies again after wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Sleep request, acted on at its rising edge |
| sleep_mode | input | 3 | Requested low-power mode code |
| xtal_opt | input | 1 | External crystal/resonator clock option selected |
| tmr_en | input | 1 | Timer enabled |
| tmr_async_sel | input | 1 | Timer uses asynchronous oscillator (1) or synchronous clock (0) |
| disp_en | input | 1 | Display controller enabled |
| disp_async_sel | input | 1 | Display controller uses asynchronous oscillator (1) or synchronous clock (0) |
| tmr_ovf_ie | input | 1 | Timer overflow interrupt enable |
| tmr_cmp_ie | input | 1 | Timer compare interrupt enable |
| gie | input | 1 | Global interrupt enable |
| tmr_ovf_evt | input | 1 | Timer overflow event |
| tmr_cmp_evt | input | 1 | Timer compare event |
| disp_irq | input | 1 | Display controller interrupt |
| ext_wake | input | 1 | External wake line |
| prr_we | input | 1 | Power-reduction mask write strobe |
| prr_wdata | input | NP | Power-reduction mask write data |
| cpu_run | output | 1 | CPU clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| async_osc_en | output | 1 | Asynchronous low-frequency oscillator enable |
| tmr_clk_en | output | 1 | Timer clock enable |
| disp_clk_en | output | 1 | Display controller clock enable |
| periph_clk_en | output | NP | Per-peripheral clock enables |

## Verification
The assertions check relations that hold on every cycle. Peripheral clocks stay off in every deep state, power-down drives all enables to 0, and standby keeps only the main oscillator. An unused mode code is never accepted, and the asynchronous oscillator stays off in power-save when no enabled module selects it. Other behaviours depend on a sequence of events, and only the bench scenarios show them. These are the exact six-edge restart, a wake event absorbed halfway through the count, a held request that does not re-enter sleep, and a mask that comes back unchanged after power-down. The bench sweeps every mode code with both crystal settings, every source-select combination in power-save, every wake-qualifier combination and every mask value.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_IDLE    = 3'd1,
    ST_PSAVE   = 3'd2,
    ST_PDOWN   = 3'd3,
    ST_STBY    = 3'd4,
    ST_RESTART = 3'd5
  } slp_state_e;

  localparam logic [2:0] MODE_IDLE  = 3'b000;
  localparam logic [2:0] MODE_PDOWN = 3'b010;
  localparam logic [2:0] MODE_PSAVE = 3'b011;
  localparam logic [2:0] MODE_STBY  = 3'b110;

  // Target state of a sleep request; ST_ACTIVE means "ignore".
  function automatic slp_state_e decode_mode(input logic [2:0] mode, input logic xtal);
    case (mode)
      MODE_IDLE:  return ST_IDLE;
      MODE_PDOWN: return ST_PDOWN;
      MODE_PSAVE: return ST_PSAVE;
      MODE_STBY:  return xtal ? ST_STBY : ST_PDOWN;
      default:    return ST_ACTIVE;
    endcase
  endfunction

  function automatic logic tmr_evt_qual(input logic ovf, input logic ovf_ie,
                                        input logic cmp, input logic cmp_ie,
                                        input logic g_ie);
    return g_ie & ((ovf & ovf_ie) | (cmp & cmp_ie));
  endfunction

  // Which wake sources count in each state.
  function automatic logic wake_hit(input slp_state_e st, input logic ext,
                                    input logic periph_wake);
    case (st)
      ST_IDLE, ST_PSAVE: return ext | periph_wake;
      ST_PDOWN, ST_STBY: return ext;
      default:           return 1'b0;
    endcase
  endfunction

  function automatic logic need_main_osc(input slp_state_e st, input logic sync_user);
    case (st)
      ST_ACTIVE, ST_IDLE, ST_STBY, ST_RESTART: return 1'b1;
      ST_PSAVE:                                return sync_user;
      default:                                 return 1'b0;
    endcase
  endfunction

  function automatic logic need_async_osc(input slp_state_e st, input logic async_user);
    case (st)
      ST_ACTIVE, ST_IDLE: return 1'b1;
      ST_PSAVE:           return async_user;
      default:            return 1'b0;
    endcase
  endfunction

  function automatic logic periph_domain_on(input slp_state_e st);
    return (st == ST_ACTIVE) || (st == ST_IDLE);
  endfunction

  function automatic logic timed_domain_on(input slp_state_e st);
    return (st == ST_ACTIVE) || (st == ST_IDLE) || (st == ST_PSAVE);
  endfunction

endpackage

// File: rtl/slp_wake_qual.sv
module slp_wake_qual
  import slp_pkg::*;
(
  input  slp_state_e st,
  input  logic       ext_wake,
  input  logic       disp_irq,
  input  logic       tmr_ovf_evt,
  input  logic       tmr_ovf_ie,
  input  logic       tmr_cmp_evt,
  input  logic       tmr_cmp_ie,
  input  logic       gie,
  output logic       wake
);
  logic tmr_wake;

  assign tmr_wake = tmr_evt_qual(tmr_ovf_evt, tmr_ovf_ie, tmr_cmp_evt, tmr_cmp_ie, gie);
  assign wake     = wake_hit(st, ext_wake, tmr_wake | disp_irq);
endmodule

// File: rtl/slp_mode_fsm.sv
module slp_mode_fsm
  import slp_pkg::*;
#(
  parameter int RESTART_CYC = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic [2:0] sleep_mode,
  input  logic       xtal_opt,
  input  logic       wake,
  output slp_state_e st,
  output logic       sleep_acc
);
  localparam int CNT_W = (RESTART_CYC > 2) ? $clog2(RESTART_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESTART_CYC - 1);

  slp_state_e       st_q, st_d, target;
  logic             req_q, req_edge, restart_done;
  logic [CNT_W-1:0] cnt_q;

  assign target       = decode_mode(sleep_mode, xtal_opt);
  assign req_edge     = sleep_req & ~req_q;
  assign sleep_acc    = (st_q == ST_ACTIVE) && req_edge && (target != ST_ACTIVE);
  assign restart_done = (st_q == ST_RESTART) && (cnt_q == '0);
  assign st           = st_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_ACTIVE:                   if (sleep_acc)    st_d = target;
      ST_IDLE, ST_PSAVE, ST_PDOWN: if (wake)         st_d = ST_ACTIVE;
      ST_STBY:                     if (wake)         st_d = ST_RESTART;
      ST_RESTART:                  if (restart_done) st_d = ST_ACTIVE;
      default:                                       st_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ACTIVE;
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      req_q <= sleep_req;
      if (st_q == ST_STBY && wake)
        cnt_q <= CNT_LOAD;
      else if (st_q == ST_RESTART && cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/slp_clk_gate.sv
module slp_clk_gate
  import slp_pkg::*;
#(
  parameter int NP = 4
) (
  input  slp_state_e    st,
  input  logic [NP-1:0] prr,
  input  logic          tmr_en,
  input  logic          tmr_async_sel,
  input  logic          disp_en,
  input  logic          disp_async_sel,
  output logic          cpu_run,
  output logic          main_osc_en,
  output logic          async_osc_en,
  output logic          tmr_clk_en,
  output logic          disp_clk_en,
  output logic [NP-1:0] periph_clk_en
);
  logic sync_user, async_user, pdom_on;

  assign sync_user  = (tmr_en & ~tmr_async_sel) | (disp_en & ~disp_async_sel);
  assign async_user = (tmr_en &  tmr_async_sel) | (disp_en &  disp_async_sel);
  assign pdom_on    = periph_domain_on(st);

  assign cpu_run      = (st == ST_ACTIVE);
  assign main_osc_en  = need_main_osc(st, sync_user);
  assign async_osc_en = need_async_osc(st, async_user);
  assign tmr_clk_en   = timed_domain_on(st) & tmr_en;
  assign disp_clk_en  = timed_domain_on(st) & disp_en;

  for (genvar g = 0; g < NP; g++) begin : g_periph
    assign periph_clk_en[g] = pdom_on & ~prr[g];
  end
endmodule

// File: rtl/slp_clk_ctrl.sv
module slp_clk_ctrl
  import slp_pkg::*;
#(
  parameter int NP          = 4,
  parameter int RESTART_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req,
  input  logic [2:0]    sleep_mode,
  input  logic          xtal_opt,
  input  logic          tmr_en,
  input  logic          tmr_async_sel,
  input  logic          disp_en,
  input  logic          disp_async_sel,
  input  logic          tmr_ovf_ie,
  input  logic          tmr_cmp_ie,
  input  logic          gie,
  input  logic          tmr_ovf_evt,
  input  logic          tmr_cmp_evt,
  input  logic          disp_irq,
  input  logic          ext_wake,
  input  logic          prr_we,
  input  logic [NP-1:0] prr_wdata,
  output logic          cpu_run,
  output logic          main_osc_en,
  output logic          async_osc_en,
  output logic          tmr_clk_en,
  output logic          disp_clk_en,
  output logic [NP-1:0] periph_clk_en
);
  slp_state_e    st;
  logic          wake, sleep_acc;
  logic [NP-1:0] prr_q;

  // Named state flags for the bound checker.
  logic st_idle, st_psave, st_pdown, st_stby, st_restart;
  assign st_idle    = (st == ST_IDLE);
  assign st_psave   = (st == ST_PSAVE);
  assign st_pdown   = (st == ST_PDOWN);
  assign st_stby    = (st == ST_STBY);
  assign st_restart = (st == ST_RESTART);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prr_q <= '0;
    else if (prr_we) prr_q <= prr_wdata;
  end

  slp_wake_qual i_wake (
    .st(st), .ext_wake(ext_wake), .disp_irq(disp_irq),
    .tmr_ovf_evt(tmr_ovf_evt), .tmr_ovf_ie(tmr_ovf_ie),
    .tmr_cmp_evt(tmr_cmp_evt), .tmr_cmp_ie(tmr_cmp_ie),
    .gie(gie), .wake(wake)
  );

  slp_mode_fsm #(.RESTART_CYC(RESTART_CYC)) i_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
    .xtal_opt(xtal_opt), .wake(wake), .st(st), .sleep_acc(sleep_acc)
  );

  slp_clk_gate #(.NP(NP)) i_gate (
    .st(st), .prr(prr_q), .tmr_en(tmr_en), .tmr_async_sel(tmr_async_sel),
    .disp_en(disp_en), .disp_async_sel(disp_async_sel),
    .cpu_run(cpu_run), .main_osc_en(main_osc_en), .async_osc_en(async_osc_en),
    .tmr_clk_en(tmr_clk_en), .disp_clk_en(disp_clk_en), .periph_clk_en(periph_clk_en)
  );
endmodule

// File: rtl/slp_clk_ctrl_chk.sv
module slp_clk_ctrl_chk #(
  parameter int NP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    sleep_mode,
  input logic          sleep_acc,
  input logic          cpu_run,
  input logic          st_idle,
  input logic          st_psave,
  input logic          st_pdown,
  input logic          st_stby,
  input logic          st_restart,
  input logic          main_osc_en,
  input logic          async_osc_en,
  input logic          tmr_clk_en,
  input logic          disp_clk_en,
  input logic [NP-1:0] periph_clk_en,
  input logic          tmr_en,
  input logic          tmr_async_sel,
  input logic          disp_en,
  input logic          disp_async_sel,
  input logic          gie,
  input logic          tmr_ovf_ie,
  input logic          tmr_ovf_evt,
  input logic          ext_wake
);
  logic code_unused;
  assign code_unused = !(sleep_mode == 3'd0 || sleep_mode == 3'd2 ||
                         sleep_mode == 3'd3 || sleep_mode == 3'd6);

  AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    code_unused |-> !sleep_acc);                                         // R2
  AST_ACCEPT_STOPS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_acc |=> !cpu_run);                                             // R2
  AST_IDLE_OSC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> (main_osc_en && async_osc_en && !cpu_run));              // R3
  AST_PDOWN_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    st_pdown |-> (!main_osc_en && !async_osc_en && !tmr_clk_en && !disp_clk_en && !cpu_run)); // R4
  AST_PDOWN_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pdown && !ext_wake) |=> !cpu_run);                               // R4
  AST_PSAVE_ASYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st_psave && !((tmr_en && tmr_async_sel) || (disp_en && disp_async_sel))) |-> !async_osc_en); // R6
  AST_PSAVE_OVF_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_psave && gie && tmr_ovf_ie && tmr_ovf_evt) |=> cpu_run);         // R7
  AST_STBY_OSC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    st_stby |-> (main_osc_en && !async_osc_en && !tmr_clk_en && !cpu_run)); // R8
  AST_RESTART_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    st_restart |=> (st_restart || cpu_run));                             // R9
  AST_DEEP_PERIPH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st_psave || st_pdown || st_stby || st_restart) |-> (periph_clk_en == '0)); // R11
endmodule

bind slp_clk_ctrl slp_clk_ctrl_chk #(.NP(NP)) i_chk (
  .clk(clk), .rst_n(rst_n), .sleep_mode(sleep_mode), .sleep_acc(sleep_acc),
  .cpu_run(cpu_run), .st_idle(st_idle), .st_psave(st_psave), .st_pdown(st_pdown),
  .st_stby(st_stby), .st_restart(st_restart), .main_osc_en(main_osc_en),
  .async_osc_en(async_osc_en), .tmr_clk_en(tmr_clk_en), .disp_clk_en(disp_clk_en),
  .periph_clk_en(periph_clk_en), .tmr_en(tmr_en), .tmr_async_sel(tmr_async_sel),
  .disp_en(disp_en), .disp_async_sel(disp_async_sel), .gie(gie),
  .tmr_ovf_ie(tmr_ovf_ie), .tmr_ovf_evt(tmr_ovf_evt), .ext_wake(ext_wake)
);

// File: tb/test_slp_clk_ctrl.sv
`timescale 1ns/1ps
module test_slp_clk_ctrl;
  localparam int NP = 4;
  localparam int VW = NP + 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sleep_req, xtal_opt, tmr_en, tmr_async_sel, disp_en, disp_async_sel;
  logic tmr_ovf_ie, tmr_cmp_ie, gie, tmr_ovf_evt, tmr_cmp_evt, disp_irq, ext_wake, prr_we;
  logic [2:0] sleep_mode;
  logic [NP-1:0] prr_wdata, periph_clk_en, prr_sh;
  logic cpu_run, main_osc_en, async_osc_en, tmr_clk_en, disp_clk_en;

  int n_cmp = 0, n_bad = 0;
  int emode; // 0 run,1 idle,2 psave,3 pdown,4 standby,5 restart

  slp_clk_ctrl #(.NP(NP), .RESTART_CYC(6)) i_slp_clk_ctrl (.*);

  function automatic int bench_decode(int m, logic x);
    if (m == 0) return 1;
    if (m == 2) return 3;
    if (m == 3) return 2;
    if (m == 6) return x ? 4 : 3;
    return 0;
  endfunction

  function automatic logic [VW-1:0] model(int em);
    logic cpu, mo, ao, tc, dc, syn, asy;
    logic [NP-1:0] pc;
    syn = (tmr_en && !tmr_async_sel) || (disp_en && !disp_async_sel);
    asy = (tmr_en && tmr_async_sel) || (disp_en && disp_async_sel);
    cpu = (em == 0);
    mo  = (em == 0 || em == 1 || em == 4 || em == 5) || (em == 2 && syn);
    ao  = (em <= 1) || (em == 2 && asy);
    tc  = (em <= 2) && tmr_en;
    dc  = (em <= 2) && disp_en;
    pc  = (em <= 1) ? ~prr_sh : '0;
    return {cpu, mo, ao, tc, dc, pc};
  endfunction

  task automatic chk_all(string req);
    logic [VW-1:0] act, exp_v;
    act   = {cpu_run, main_osc_en, async_osc_en, tmr_clk_en, disp_clk_en, periph_clk_en};
    exp_v = model(emode);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: act=%b exp=%b (mode %0d)", req, act, exp_v, emode);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic go_sleep(int m);
    sleep_mode = 3'(m); sleep_req = 1'b1; cyc(); sleep_req = 1'b0;
  endtask

  task automatic wake_ext(string req);
    logic was_stby;
    was_stby = (emode == 4);
    ext_wake = 1'b1; cyc(); ext_wake = 1'b0;
    if (was_stby) begin
      for (int k = 0; k < 6; k++) begin
        emode = 5; chk_all("R9");
        ext_wake = (k == 2); // absorbed mid-count
        cyc();
        ext_wake = 1'b0;
      end
    end
    emode = 0; chk_all(req);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; sleep_req = 0; sleep_mode = 0; xtal_opt = 0; tmr_en = 0; tmr_async_sel = 0;
    disp_en = 0; disp_async_sel = 0; tmr_ovf_ie = 0; tmr_cmp_ie = 0; gie = 0;
    tmr_ovf_evt = 0; tmr_cmp_evt = 0; disp_irq = 0; ext_wake = 0; prr_we = 0; prr_wdata = 0;
    prr_sh = '0; emode = 0;
    cyc(); cyc(); rst_n = 1; cyc();
    chk_all("R1");

    // R2/R3/R4/R8/R9: every code with both crystal settings
    for (int m = 0; m < 8; m++) begin
      for (int x = 0; x < 2; x++) begin
        xtal_opt = x[0];
        go_sleep(m);
        emode = bench_decode(m, x[0]);
        chk_all("R2");
        cyc(); chk_all("R2");
        if (emode != 0) wake_ext(emode == 1 ? "R3" : (emode == 3 ? "R4" : "R8"));
      end
    end
    xtal_opt = 0;

    // R2: request while asleep, and a held request, are ignored
    go_sleep(0); emode = 1; chk_all("R3");
    sleep_mode = 3'd2; sleep_req = 1; cyc(); sleep_req = 0; chk_all("R2");
    wake_ext("R3");
    sleep_mode = 3'd0; sleep_req = 1; cyc(); emode = 1; chk_all("R2");
    ext_wake = 1; cyc(); ext_wake = 0; emode = 0; chk_all("R3");
    cyc(); chk_all("R2");
    sleep_req = 0; cyc();

    // R3: display interrupt ends idle
    go_sleep(0); emode = 1;
    disp_irq = 1; cyc(); disp_irq = 0; emode = 0; chk_all("R3");

    // R5/R6: every source/enable combination in power-save
    for (int c = 0; c < 16; c++) begin
      {tmr_en, tmr_async_sel, disp_en, disp_async_sel} = 4'(c);
      go_sleep(3); emode = 2;
      chk_all("R6");
      chk_all("R5");
      wake_ext("R7");
    end
    tmr_en = 1; disp_en = 1; tmr_async_sel = 1; disp_async_sel = 0;

    // R7: timer wake qualification in power-save
    for (int v = 0; v < 32; v++) begin
      logic hit;
      go_sleep(3); emode = 2;
      {tmr_ovf_evt, tmr_ovf_ie, tmr_cmp_evt, tmr_cmp_ie, gie} = 5'(v);
      hit = gie && ((tmr_ovf_evt && tmr_ovf_ie) || (tmr_cmp_evt && tmr_cmp_ie));
      cyc();
      {tmr_ovf_evt, tmr_cmp_evt} = 2'b00;
      emode = hit ? 0 : 2;
      chk_all("R7");
      if (!hit) wake_ext("R7");
    end
    go_sleep(3); emode = 2;
    disp_irq = 1; cyc(); disp_irq = 0; emode = 0; chk_all("R7");

    // R4: power-down ignores qualified timer and display events
    tmr_ovf_ie = 1; gie = 1;
    go_sleep(2); emode = 3;
    tmr_ovf_evt = 1; disp_irq = 1; cyc(); tmr_ovf_evt = 0; disp_irq = 0;
    chk_all("R4");
    wake_ext("R4");

    // R10/R11: every mask value in run, idle and power-down
    for (int p = 0; p < 16; p++) begin
      prr_we = 1; prr_wdata = NP'(p); cyc(); prr_we = 0; prr_sh = NP'(p);
      chk_all("R10");
      go_sleep(0); emode = 1; chk_all("R10");
      wake_ext("R10");
      go_sleep(2); emode = 3; chk_all("R11");
      wake_ext("R11");
    end

    summary();
    $finish;
  end
endmodule